// File: doc/BRIEF.md
# Helicity Window History Recorder

This block watches three asynchronous beam-timing levels: the helicity bit, the settle gate and the pattern-sync marker. When the settle gate falls, a new stable helicity window begins. At that moment the block stores the three levels in a circular history of 256 windows. It also presents a delayed helicity bit, so that the reported value trails the true beam state by a programmable number of patterns. A pattern is a group of two, four or eight windows.

A pattern-sync tracker follows the pattern grid. It flags, and keeps flagged, any window where the sync marker disagrees with the expected pattern boundary. When an event trigger arrives, the history is frozen into a snapshot together with a pointer. The event builder can then read all 256 entries, oldest first, while new windows continue to be recorded.

Top module: `hel_history`

## Requirements
- R1: After reset the outputs `win_pulse`, `pat_start`, `hel_dly`, `snap_ptr`, `sync_err` and `rd_data` are all zero.
- R2: Each falling edge of `settle_in` records exactly one history entry. Every input passes through a two-stage synchronizer, so `win_pulse` is high for one cycle, three clock edges after the falling level is applied.
- R3: A history entry is 3 bits wide: bit 0 is helicity, bit 1 is the settle level at capture (always low), and bit 2 is pattern sync. All unwritten entries read as zero.
- R4: A cycle with `trig` high copies the whole history into a snapshot. `rd_data` shows snapshot entry `rd_addr`, where address 0 is the oldest slot and address 255 is the newest window. Windows recorded after the trigger leave the snapshot unchanged.
- R5: If `trig` is high in the same cycle that a window is captured, that window is part of the snapshot and appears at address 255.
- R6: The pattern length is selected by `cfg_pat_sel`: 0 gives 2 windows, 1 gives 4 windows, and 2 or 3 give 8 windows. At each window, `hel_dly` takes the helicity of the window recorded D windows earlier, where D = `cfg_pat_delay` × pattern length. When D is 0, `hel_dly` takes the current window's helicity.
- R7: D is clamped to 255 windows.
- R8: `pat_start` pulses together with `win_pulse` for every window whose pattern sync is high.
- R9: The first window with sync high locks the tracker. After lock, a window whose sync level differs from "first window of a pattern" sets `sync_err`. The flag then stays set until reset. Before lock, no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hel_in | input | 1 | Helicity level, asynchronous |
| settle_in | input | 1 | Settle gate; its falling edge starts a window |
| psync_in | input | 1 | Pattern-sync level, high in a pattern's first window |
| cfg_pat_sel | input | 2 | Pattern length select |
| cfg_pat_delay | input | 8 | Report delay in patterns |
| trig | input | 1 | Event trigger, takes a snapshot |
| rd_addr | input | 8 | Snapshot read address, 0 = oldest |
| win_pulse | output | 1 | One-cycle pulse per captured window |
| pat_start | output | 1 | Pulse for a pattern-start window |
| hel_dly | output | 1 | Delayed helicity |
| snap_ptr | output | 8 | Write slot held at the trigger (oldest entry) |
| rd_data | output | 3 | Snapshot entry at `rd_addr` |
| sync_err | output | 1 | Sticky pattern-sync error |

## Verification
A trigger and a window capture can land in the same clock cycle. In that case the snapshot must take the entry being written in that cycle, not the old contents of its slot. The bench places `trig` exactly over the capture edge of a window. It then reads address 255 and the snapshot pointer to confirm that the new window is the newest snapshot entry. It also checks that a trigger on its own, followed by further windows, leaves the snapshot unchanged.

// File: rtl/hh_pkg.sv
package hh_pkg;
  localparam int unsigned HH_DW = 3;  // {psync, settle, helicity}

  typedef enum logic [1:0] {
    PAT_PAIR = 2'd0,
    PAT_QUAD = 2'd1,
    PAT_OCT  = 2'd2,
    PAT_OCT2 = 2'd3
  } pat_sel_t;

  function automatic logic [3:0] pat_len(input logic [1:0] sel);
    case (pat_sel_t'(sel))
      PAT_PAIR: pat_len = 4'd2;
      PAT_QUAD: pat_len = 4'd4;
      default:  pat_len = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/hh_sync.sv
module hh_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] meta_q, stab_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        stab_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= d_in[g];
        stab_q[g] <= meta_q[g];
      end
    end
  end

  assign d_out = stab_q;
endmodule

// File: rtl/hh_ring.sv
module hh_ring #(
  parameter int DEPTH = 256,
  parameter int DW    = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] dly_win,
  input  logic          trig,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] dly_data,
  output logic [AW-1:0] snap_ptr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem_q  [DEPTH];
  logic [DW-1:0] snap_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_n;
  logic [AW-1:0] snap_ptr_n;

  always_comb begin
    wr_ptr_n   = wr_en ? wr_ptr_q + 1'b1 : wr_ptr_q;
    snap_ptr_n = trig ? wr_ptr_n : snap_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      snap_ptr <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      snap_ptr <= snap_ptr_n;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_ptr_q == AW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[e]  <= '0;
        snap_q[e] <= '0;
      end else begin
        if (hit)  mem_q[e]  <= wr_data;
        if (trig) snap_q[e] <= hit ? wr_data : mem_q[e];
      end
    end
  end

  assign dly_data = (dly_win == '0) ? wr_data : mem_q[wr_ptr_q - dly_win];
  assign rd_data  = snap_q[snap_ptr + rd_addr];

  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_ptr_q == AW'($past(wr_ptr_q) + 1'b1));  // R2
  AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_ptr_q));  // R2
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(snap_ptr));  // R4
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !wr_en) |=> snap_ptr == $past(wr_ptr_q));  // R4
  AST_SNAP_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && wr_en) |=> snap_ptr == wr_ptr_q);  // R5
endmodule

// File: rtl/hh_pattern.sv
module hh_pattern (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       win_stb,
  input  logic       psync,
  input  logic [1:0] sel,
  output logic       sync_err
);
  import hh_pkg::*;

  logic [2:0] pos_q, pos_n;
  logic       lock_q, lock_n;
  logic       err_n;
  logic [3:0] len;

  assign len = pat_len(sel);

  always_comb begin
    pos_n  = pos_q;
    lock_n = lock_q;
    err_n  = sync_err;
    if (win_stb) begin
      if (lock_q && (psync != (pos_q == 3'd0))) err_n = 1'b1;
      if (psync) begin
        lock_n = 1'b1;
        pos_n  = 3'd1;
      end else if ({1'b0, pos_q} == len - 4'd1) begin
        pos_n = 3'd0;
      end else begin
        pos_n = pos_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      lock_q   <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      pos_q    <= pos_n;
      lock_q   <= lock_n;
      sync_err <= err_n;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> sync_err);  // R9
  AST_NO_ERR_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |-> !sync_err);  // R9
endmodule

// File: rtl/hel_history.sv
module hel_history #(
  parameter int DEPTH = 256,
  parameter int DLYW  = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = hh_pkg::HH_DW,
  localparam int PW   = DLYW + 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hel_in,
  input  logic            settle_in,
  input  logic            psync_in,
  input  logic [1:0]      cfg_pat_sel,
  input  logic [DLYW-1:0] cfg_pat_delay,
  input  logic            trig,
  input  logic [AW-1:0]   rd_addr,
  output logic            win_pulse,
  output logic            pat_start,
  output logic            hel_dly,
  output logic [AW-1:0]   snap_ptr,
  output logic [DW-1:0]   rd_data,
  output logic            sync_err
);
  import hh_pkg::*;

  logic [2:0]    lvl_s;
  logic          hel_s, settle_s, psync_s;
  logic          settle_d;
  logic          win_stb;
  logic [DW-1:0] entry;
  logic [DW-1:0] dly_entry;
  logic [PW-1:0] dly_prod;
  logic [AW-1:0] dly_win;
  logic          win_pulse_n, pat_start_n, hel_dly_n;

  hh_sync #(.W(3)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in ({psync_in, settle_in, hel_in}),
    .d_out(lvl_s)
  );
  assign {psync_s, settle_s, hel_s} = lvl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_d <= 1'b0;
    else        settle_d <= settle_s;
  end

  assign win_stb = settle_d && !settle_s;
  assign entry   = {psync_s, settle_s, hel_s};

  always_comb begin
    dly_prod = PW'(cfg_pat_delay) * PW'(pat_len(cfg_pat_sel));
    dly_win  = (dly_prod > PW'(DEPTH - 1)) ? AW'(DEPTH - 1) : dly_prod[AW-1:0];
  end

  hh_ring #(.DEPTH(DEPTH), .DW(DW)) i_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (win_stb),
    .wr_data (entry),
    .dly_win (dly_win),
    .trig    (trig),
    .rd_addr (rd_addr),
    .dly_data(dly_entry),
    .snap_ptr(snap_ptr),
    .rd_data (rd_data)
  );

  hh_pattern i_pattern (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_stb (win_stb),
    .psync   (psync_s),
    .sel     (cfg_pat_sel),
    .sync_err(sync_err)
  );

  always_comb begin
    win_pulse_n = win_stb;
    pat_start_n = win_stb && psync_s;
    hel_dly_n   = win_stb ? dly_entry[0] : hel_dly;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_pulse <= 1'b0;
      pat_start <= 1'b0;
      hel_dly   <= 1'b0;
    end else begin
      win_pulse <= win_pulse_n;
      pat_start <= pat_start_n;
      hel_dly   <= hel_dly_n;
    end
  end

  AST_PAT_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    pat_start |-> win_pulse);  // R8
  AST_WIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    win_pulse |=> !win_pulse);  // R2
  AST_DLY_ONLY_AT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    !win_pulse |-> $stable(hel_dly));  // R6
endmodule

// File: tb/test_hel_history.sv
module test_hel_history;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hel_in, settle_in, psync_in;
  logic [1:0] cfg_pat_sel;
  logic [7:0] cfg_pat_delay;
  logic       trig;
  logic [7:0] rd_addr;
  logic       win_pulse, pat_start, hel_dly, sync_err;
  logic [7:0] snap_ptr;
  logic [2:0] rd_data;

  int checks = 0;
  int errors = 0;

  logic [2:0] hist [256];
  logic [2:0] snap_m [256];
  logic       hel_log [1024];
  int wcnt;
  int snap_cnt;
  int cur_d;

  always #10 clk = ~clk;

  hel_history i_hel_history (
    .clk(clk), .rst_n(rst_n), .hel_in(hel_in), .settle_in(settle_in),
    .psync_in(psync_in), .cfg_pat_sel(cfg_pat_sel), .cfg_pat_delay(cfg_pat_delay),
    .trig(trig), .rd_addr(rd_addr), .win_pulse(win_pulse), .pat_start(pat_start),
    .hel_dly(hel_dly), .snap_ptr(snap_ptr), .rd_data(rd_data), .sync_err(sync_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit hel_of(input int k);
    return bit'(((k * 3) ^ (k >> 2)) & 1);
  endfunction

  task automatic do_reset(input logic [1:0] sel, input int dly);
    int len;
    len = (sel == 2'd0) ? 2 : (sel == 2'd1) ? 4 : 8;
    cur_d = dly * len;
    if (cur_d > 255) cur_d = 255;
    cfg_pat_sel = sel;
    cfg_pat_delay = 8'(dly);
    rst_n = 1'b0;
    hel_in = 1'b0; settle_in = 1'b0; psync_in = 1'b0; trig = 1'b0; rd_addr = '0;
    for (int i = 0; i < 256; i++) begin hist[i] = '0; snap_m[i] = '0; end
    wcnt = 0; snap_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one window; sampling happens at the third negedge after settle falls
  task automatic send_win(input bit h, input bit ps, input bit tr);
    int k;
    bit exp_h;
    @(negedge clk);
    hel_in = h; psync_in = ps; settle_in = 1'b1;
    repeat (4) @(negedge clk);
    settle_in = 1'b0;
    repeat (2) @(negedge clk);
    trig = tr;
    @(negedge clk);
    trig = 1'b0;
    k = wcnt;
    hist[k % 256] = {ps, 1'b0, h};
    hel_log[k] = h;
    wcnt++;
    if (tr) begin
      for (int i = 0; i < 256; i++) snap_m[i] = hist[i];
      snap_cnt = wcnt;
    end
    exp_h = (k - cur_d >= 0) ? hel_log[k - cur_d] : 1'b0;
    chk(win_pulse == 1'b1, "R2 win_pulse", int'(win_pulse), 1);
    chk(pat_start == ps, "R8 pat_start", int'(pat_start), int'(ps));
    chk(hel_dly == exp_h, (cur_d == 255) ? "R7 hel_dly clamp" : "R6 hel_dly",
        int'(hel_dly), int'(exp_h));
    @(negedge clk);
    chk(win_pulse == 1'b0, "R2 pulse width", int'(win_pulse), 0);
  endtask

  task automatic pulse_trig;
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int i = 0; i < 256; i++) snap_m[i] = hist[i];
    snap_cnt = wcnt;
  endtask

  task automatic read_all(input string req);
    chk(snap_ptr == 8'(snap_cnt % 256), "R4 snap_ptr", int'(snap_ptr), snap_cnt % 256);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      rd_addr = 8'(a);
      #2;
      chk(rd_data == snap_m[(snap_cnt + a) % 256], req, int'(rd_data),
          int'(snap_m[(snap_cnt + a) % 256]));
    end
  endtask

  task automatic t_reset;  // R1
    do_reset(2'd1, 1);
    chk(win_pulse == 0 && pat_start == 0 && hel_dly == 0, "R1 outputs",
        int'({win_pulse, pat_start, hel_dly}), 0);
    chk(snap_ptr == 0, "R1 snap_ptr", int'(snap_ptr), 0);
    chk(sync_err == 0, "R1 sync_err", int'(sync_err), 0);
    rd_addr = 8'd77; #2;
    chk(rd_data == 0, "R1 rd_data", int'(rd_data), 0);
  endtask

  task automatic t_quartet;  // R2 R6 R8
    do_reset(2'd1, 1);
    for (int k = 0; k < 14; k++) send_win(hel_of(k), (k % 4) == 0, 1'b0);
    chk(sync_err == 0, "R9 no error on clean grid", int'(sync_err), 0);
  endtask

  task automatic t_zero_delay;  // R6
    do_reset(2'd0, 0);
    for (int k = 0; k < 5; k++) send_win(hel_of(k + 1), (k % 2) == 0, 1'b0);
  endtask

  task automatic t_snapshot;  // R3 R4
    do_reset(2'd0, 2);
    for (int k = 0; k < 20; k++) send_win(hel_of(k), (k % 2) == 0, 1'b0);
    pulse_trig();
    for (int k = 20; k < 26; k++) send_win(~hel_of(k), (k % 2) == 0, 1'b0);
    read_all("R4 snapshot entry");
    chk(rd_data == 3'b000 || rd_data == 3'b001 || rd_data == 3'b100 || rd_data == 3'b101,
        "R3 settle bit low", int'(rd_data[1]), 0);
  endtask

  task automatic t_collide;  // R5
    do_reset(2'd1, 0);
    for (int k = 0; k < 6; k++) send_win(hel_of(k), (k % 4) == 0, 1'b0);
    send_win(1'b1, 1'b0, 1'b1);
    chk(snap_ptr == 8'd7, "R5 snap_ptr after collide", int'(snap_ptr), 7);
    @(negedge clk); rd_addr = 8'd255; #2;
    chk(rd_data == 3'b001, "R5 newest entry in snapshot", int'(rd_data), 1);
    send_win(1'b0, 1'b0, 1'b0);
    read_all("R5 snapshot entry");
  endtask

  task automatic t_clamp;  // R7
    do_reset(2'd2, 40);
    for (int k = 0; k < 262; k++) send_win(hel_of(k), (k % 8) == 0, 1'b0);
    chk(sync_err == 0, "R9 octet grid clean", int'(sync_err), 0);
  endtask

  task automatic t_sync_err;  // R9
    do_reset(2'd0, 1);
    for (int k = 0; k < 3; k++) send_win(1'b0, 1'b0, 1'b0);
    chk(sync_err == 0, "R9 no error before lock", int'(sync_err), 0);
    send_win(1'b1, 1'b1, 1'b0);
    send_win(1'b0, 1'b0, 1'b0);
    send_win(1'b1, 1'b1, 1'b0);
    chk(sync_err == 0, "R9 locked clean", int'(sync_err), 0);
    send_win(1'b1, 1'b1, 1'b0);
    chk(sync_err == 1, "R9 error on misplaced sync", int'(sync_err), 1);
    send_win(1'b0, 1'b0, 1'b0);
    send_win(1'b1, 1'b1, 1'b0);
    chk(sync_err == 1, "R9 error sticky", int'(sync_err), 1);
    do_reset(2'd0, 1);
    send_win(1'b1, 1'b1, 1'b0);
    send_win(1'b0, 1'b1, 1'b0);
    chk(sync_err == 1, "R9 sync inside pattern", int'(sync_err), 1);
  endtask

  initial begin
    t_reset();
    t_quartet();
    t_zero_delay();
    t_snapshot();
    t_collide();
    t_clamp();
    t_sync_err();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule